// File: doc/BRIEF.md
# Greedy Equalizer Tap Trim Controller

This controller lowers the power of a feed-forward equalizer by switching off its least useful taps once adaptation has settled. After a start pulse it scans the current tap coefficient magnitudes and finds the smallest tap that is still enabled and allowed to go. It clears that tap's enable bit, then waits for an evaluation window counted in external `eval_tick` pulses. At the end of the window it reads a margin verdict supplied from outside.

If the margin holds, the controller picks the next-smallest tap and repeats. If the margin fails, it turns the tap it just removed back on and stops. The search has no fixed drop count and no magnitude threshold: it ends either at the first tap whose removal breaks the margin, or when every eligible tap is off.

The main cursor and the first post-cursor tap are never candidates. With the default 31 taps, at most 29 can be disabled. Coefficient adaptation, margin estimation and the equalizer datapath are outside this block.

Top module: `ffe_tap_trim`

## Requirements
- R1: After reset every bit of `tap_en` is 1, and `busy` and `done` are both 0.
- R2: The main cursor (tap index 6) and the first post-cursor tap (tap index 7) are never disabled, even when their magnitudes are the smallest.
- R3: A `start` pulse while `busy` is 0 sets every bit of `tap_en` to 1 and raises `busy` on the next cycle.
- R4: Each step clears exactly one bit of `tap_en`. That bit belongs to the enabled, eligible tap with the smallest magnitude, and a tie goes to the lower tap index. Tap i's magnitude is `tap_mag[8*i +: 8]`.
- R5: While a verdict is awaited, `tap_en` is stable and `busy` stays 1. The verdict is taken on the 10th `eval_tick` pulse after the tap was cleared.
- R6: If `margin_ok` is 1 at the verdict, the controller goes on to clear the next tap.
- R7: If `margin_ok` is 0 at the verdict, the last cleared tap is set to 1 again, `done` goes to 1 and `busy` goes to 0.
- R8: If all eligible taps are disabled with passing verdicts, the controller ends with `done` = 1 and exactly 29 zeros in `tap_en`.
- R9: While `done` is 1, `tap_en` is frozen regardless of `tap_mag`, `eval_tick` or `margin_ok`. A `start` while `busy` is 1 is ignored.
- R10: `eval_tick` pulses that arrive while the controller is scanning do not count toward the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a new search |
| tap_mag | input | 248 | Packed tap magnitudes, 8 bits per tap, tap i at bits 8*i+7:8*i |
| eval_tick | input | 1 | One pulse per adaptation update period |
| margin_ok | input | 1 | Margin verdict, 1 = margin passes |
| tap_en | output | 31 | Per-tap enable mask to the equalizer |
| done | output | 1 | Search finished, mask frozen |
| busy | output | 1 | Search in progress |

## Verification
The bench builds the block with its default parameters: 31 taps, 8-bit magnitudes, cursor at index 6, fixed post-cursor at index 7, and a 10-tick window. Because the window is counted in ticks that the bench supplies, a complete 29-step search in which every verdict passes fits in a short run.

Pinning the main-cursor and post-cursor magnitudes to zero probes whether the exclusion holds. Making every magnitude equal probes the tie-break order. Sending nine ticks, ticks during a scan, and a stray start while busy probes the window boundary and the input filtering.

// File: rtl/ffe_tap_trim_pkg.sv
// Shared types for the tap trim controller.
// Assumes: nothing beyond the standard language.
package ffe_tap_trim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } trim_state_t;
endpackage

// File: rtl/ffe_tap_elig.sv
// Builds the static mask of taps that the search may switch off.
// Assumes: MAIN_IDX and FIXED_IDX are below N_TAPS.
module ffe_tap_elig #(
    parameter int N_TAPS    = 31,
    parameter int MAIN_IDX  = 6,
    parameter int FIXED_IDX = 7
) (
    output logic [N_TAPS-1:0] elig
);
    for (genvar gi = 0; gi < N_TAPS; gi++) begin : g_tap
        // Purpose: mark a tap eligible unless it is the cursor or the fixed tap.
        assign elig[gi] = (gi != MAIN_IDX) && (gi != FIXED_IDX);
    end
endmodule

// File: rtl/ffe_tap_scan.sv
// Sequential minimum search: visits one tap per cycle for N_TAPS cycles and
// reports the lowest-index tap of smallest magnitude among the candidates.
// Assumes: cand and mags are held steady for the whole scan.
module ffe_tap_scan #(
    parameter int N_TAPS = 31,
    parameter int MAG_W  = 8,
    localparam int IDX_W = $clog2(N_TAPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [N_TAPS-1:0]       cand,
    input  logic [N_TAPS*MAG_W-1:0] mags,
    output logic                    fin,
    output logic                    found,
    output logic [IDX_W-1:0]        best_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_TAPS - 1);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic             found_q;
    logic [MAG_W-1:0] best_mag_q;
    logic [IDX_W-1:0] best_idx_q;
    logic [MAG_W-1:0] cur_mag;
    logic             take;

    // Purpose: compare the visited tap against the running best.
    always_comb begin
        cur_mag  = mags[int'(idx_q)*MAG_W +: MAG_W];
        take     = active_q && cand[idx_q] && (!found_q || (cur_mag < best_mag_q));
        found    = found_q || (active_q && cand[idx_q]);
        best_idx = take ? idx_q : best_idx_q;
        fin      = active_q && (idx_q == LAST);
    end

    // Purpose: step the scan index and hold the running minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            idx_q      <= '0;
            found_q    <= 1'b0;
            best_mag_q <= '0;
            best_idx_q <= '0;
        end else if (go) begin
            active_q   <= 1'b1;
            idx_q      <= '0;
            found_q    <= 1'b0;
            best_mag_q <= '0;
            best_idx_q <= '0;
        end else if (active_q) begin
            found_q <= found;
            if (take) begin
                best_mag_q <= cur_mag;
                best_idx_q <= idx_q;
            end
            if (idx_q == LAST) active_q <= 1'b0;
            else               idx_q    <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/ffe_tap_window.sv
// Counts evaluation ticks while enabled and flags the final tick of a window.
// Assumes: en drops for at least one cycle between windows.
module ffe_tap_window #(
    parameter int EVAL_TICKS = 10,
    localparam int CNT_W = $clog2(EVAL_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic win_end
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: flag the tick that completes the window.
    assign win_end = en && tick && (cnt_q == CNT_W'(EVAL_TICKS - 1));

    // Purpose: count ticks inside a window, clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (tick && !win_end) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ffe_tap_trim.sv
// Top of the greedy tap trim controller: drives the enable mask through
// scan, wait and verdict steps, and rolls back the last tap on a failed margin.
// Assumes: tap_mag is steady during a search; eval_tick is a one-cycle pulse.
module ffe_tap_trim
    import ffe_tap_trim_pkg::*;
#(
    parameter int N_TAPS     = 31,
    parameter int MAG_W      = 8,
    parameter int MAIN_IDX   = 6,
    parameter int FIXED_IDX  = 7,
    parameter int EVAL_TICKS = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_TAPS*MAG_W-1:0] tap_mag,
    input  logic                    eval_tick,
    input  logic                    margin_ok,
    output logic [N_TAPS-1:0]       tap_en,
    output logic                    done,
    output logic                    busy
);
    localparam int IDX_W = $clog2(N_TAPS);

    trim_state_t      st_q;
    logic [IDX_W-1:0] last_q;
    logic [N_TAPS-1:0] elig;
    logic             scan_go;
    logic             scan_fin;
    logic             scan_found;
    logic [IDX_W-1:0] scan_idx;
    logic             win_end;
    logic             launch;

    ffe_tap_elig #(.N_TAPS(N_TAPS), .MAIN_IDX(MAIN_IDX), .FIXED_IDX(FIXED_IDX))
        u_elig (.elig(elig));

    ffe_tap_scan #(.N_TAPS(N_TAPS), .MAG_W(MAG_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .go(scan_go), .cand(tap_en & elig),
        .mags(tap_mag), .fin(scan_fin), .found(scan_found), .best_idx(scan_idx)
    );

    ffe_tap_window #(.EVAL_TICKS(EVAL_TICKS)) u_win (
        .clk(clk), .rst_n(rst_n), .en(st_q == ST_WAIT), .tick(eval_tick),
        .win_end(win_end)
    );

    // Purpose: decode status flags and the scan launch condition.
    always_comb begin
        busy    = (st_q == ST_SCAN) || (st_q == ST_WAIT);
        done    = (st_q == ST_DONE);
        launch  = start && !busy;
        scan_go = launch || ((st_q == ST_WAIT) && win_end && margin_ok);
    end

    // Purpose: search state machine and enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            tap_en <= '1;
            last_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (launch) begin
                        tap_en <= '1;
                        st_q   <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (scan_fin) begin
                        if (scan_found) begin
                            tap_en[scan_idx] <= 1'b0;
                            last_q           <= scan_idx;
                            st_q             <= ST_WAIT;
                        end else begin
                            st_q <= ST_DONE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (win_end) begin
                        if (margin_ok) begin
                            st_q <= ST_SCAN;
                        end else begin
                            tap_en[last_q] <= 1'b1;
                            st_q           <= ST_DONE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ffe_tap_trim_chk.sv
// Checker for the tap trim controller, attached by bind below.
// Assumes: observes top-level ports only.
module ffe_tap_trim_chk #(
    parameter int N_TAPS    = 31,
    parameter int MAIN_IDX  = 6,
    parameter int FIXED_IDX = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [N_TAPS-1:0] tap_en,
    input logic              busy,
    input logic              done
);
    AST_PROTECTED_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[MAIN_IDX] && tap_en[FIXED_IDX]); // R2
    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && (tap_en == '1))); // R3
    AST_ONE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones($past(tap_en) & ~tap_en) <= 1)); // R4
    AST_ROLLBACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($countones($past(tap_en) ^ tap_en) <= 1)); // R7
    AST_FROZEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(tap_en))); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R7
endmodule

bind ffe_tap_trim ffe_tap_trim_chk #(
    .N_TAPS(N_TAPS), .MAIN_IDX(MAIN_IDX), .FIXED_IDX(FIXED_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_en(tap_en),
    .busy(busy), .done(done)
);

// File: tb/tb_ffe_tap_trim.sv
module tb_ffe_tap_trim;
    localparam int N = 31;
    localparam int W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N*W-1:0]  tap_mag = '0;
    logic            eval_tick = 1'b0;
    logic            margin_ok = 1'b0;
    logic [N-1:0]    tap_en;
    logic            done;
    logic            busy;

    int checks = 0;
    int fails = 0;
    logic [W-1:0] m [N];

    ffe_tap_trim dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tap_mag(tap_mag),
        .eval_tick(eval_tick), .margin_ok(margin_ok),
        .tap_en(tap_en), .done(done), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_mags();
        for (int i = 0; i < N; i++) tap_mag[i*W +: W] = m[i];
    endtask

    function automatic int exp_min(input logic [N-1:0] mask);
        int b = -1;
        for (int i = 0; i < N; i++)
            if (i != 6 && i != 7 && mask[i] && (b < 0 || m[i] < m[b])) b = i;
        return b;
    endfunction

    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk);
        chk(busy === 1'b1 && tap_en === '1, "R3", "busy/mask after start",
            {busy, tap_en}, {1'b1, {N{1'b1}}});
        start = 1'b0;
    endtask

    task automatic wait_clear(output int idx);
        logic [N-1:0] prev = tap_en;
        idx = -1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tap_en !== prev) break;
        end
        for (int i = 0; i < N; i++) if (prev[i] && !tap_en[i]) idx = i;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) eval_tick = 1'b1;
            @(negedge clk) eval_tick = 1'b0;
        end
    endtask

    task automatic step(inout logic [N-1:0] emask, input bit ok);
        int got;
        int e = exp_min(emask);
        wait_clear(got);
        chk(got == e, "R4", "tap cleared", got, e);
        emask[e] = 1'b0;
        margin_ok = ok;
        ticks(10);
        if (!ok) begin
            emask[e] = 1'b1;
            chk(done === 1'b1 && busy === 1'b0, "R7", "done/busy after fail",
                {done, busy}, 2'b10);
            chk(tap_en === emask, "R7", "mask after rollback", tap_en, emask);
        end else begin
            chk(busy === 1'b1 && done === 1'b0, "R6", "continues after pass",
                {done, busy}, 2'b01);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tap_en === '1 && busy === 1'b0 && done === 1'b0, "R1", "reset state",
            {tap_en, busy, done}, {{N{1'b1}}, 2'b00});
        rst_n = 1'b1;
    endtask

    task automatic t_order();
        logic [N-1:0] em = '1;
        for (int i = 0; i < N; i++) m[i] = W'(200 - 5 * i);
        m[20] = 3; m[2] = 9; m[15] = 4;
        load_mags();
        do_start();
        step(em, 1'b1);
        step(em, 1'b1);
        step(em, 1'b0);
    endtask

    task automatic t_ties();
        logic [N-1:0] em = '1;
        for (int i = 0; i < N; i++) m[i] = 8'd50;
        load_mags();
        do_start();
        for (int s = 0; s < 7; s++) step(em, 1'b1);
        step(em, 1'b0);
        chk(tap_en[7:0] === 8'hC0, "R4", "tie order low index first", tap_en[7:0], 8'hC0);
    endtask

    task automatic t_full();
        logic [N-1:0] em = '1;
        for (int i = 0; i < N; i++) m[i] = W'((i * 37 + 11) % 256);
        m[6] = 0; m[7] = 0;
        load_mags();
        do_start();
        for (int s = 0; s < 29; s++) step(em, 1'b1);
        for (int k = 0; k < 100 && done !== 1'b1; k++) @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R8", "done after full run",
            {done, busy}, 2'b10);
        chk(N - $countones(tap_en) == 29, "R8", "zeros in mask",
            N - $countones(tap_en), 29);
        chk(tap_en[6] === 1'b1 && tap_en[7] === 1'b1, "R2", "protected taps kept",
            tap_en[7:6], 2'b11);
    endtask

    task automatic t_filter();
        int got;
        logic [N-1:0] snap;
        for (int i = 0; i < N; i++) m[i] = W'(100 + i);
        load_mags();
        margin_ok = 1'b0;
        do_start();
        ticks(5);  // these fall inside the scan
        wait_clear(got);
        chk(got == 0, "R4", "first cleared tap", got, 0);
        snap = tap_en;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(tap_en === snap && busy === 1'b1, "R9", "start while busy ignored",
            tap_en, snap);
        ticks(9);
        chk(tap_en === snap && busy === 1'b1, "R5", "mask held before 10th tick",
            tap_en, snap);
        chk(done === 1'b0, "R10", "scan ticks not counted", done, 0);
        ticks(1);
        chk(done === 1'b1 && tap_en === '1, "R7", "rollback on 10th tick",
            {done, tap_en}, {1'b1, {N{1'b1}}});
        for (int i = 0; i < N; i++) m[i] = 8'd1;
        load_mags();
        margin_ok = 1'b1;
        ticks(12);
        chk(tap_en === '1 && done === 1'b1, "R9", "frozen while done",
            {done, tap_en}, {1'b1, {N{1'b1}}});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_ties();
        t_full();
        t_filter();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule